// File: doc/BRIEF.md
# Unaligned Word Merge Unit

This block does the byte lane merging behind the four partial-word access instructions of a 32-bit little-endian processor: load-left, load-right, store-left and store-right. Each of these touches only part of a word. The part depends on the two low bits of the byte address, and the rest of the old register or memory word is kept.

The pipeline gives the unit four inputs: the unaligned byte address, the operation, the word read from the aligned location, and the current contents of the target register. The register value is the true architectural contents, with no load-delay forwarding applied.

- For a load, the unit returns the merged register value.
- For a store, it returns the merged memory word and the word-aligned address to write it to.

All results are registered and appear one cycle after the valid input, together with a valid strobe. Sequencing the memory accesses and detecting exceptions are done elsewhere.

Top module: `uwm_unit`

## Requirements
- R1: While reset is held, and after it is released with no valid input, out_valid, out_is_store, out_data and out_addr are all zero.
- R2: out_valid is high in exactly the cycle after each cycle in which in_valid is high, and low otherwise.
- R3: out_addr equals the captured in_addr with its two low bits forced to zero.
- R4: Operation code 2'b00 (load-left), with k = in_addr[1:0]: result byte i (byte 0 at bits 7:0) is memory byte i-(3-k) when i >= 3-k, and register byte i otherwise.
- R5: Operation code 2'b01 (load-right): result byte i is memory byte i+k when i <= 3-k, and register byte i otherwise.
- R6: Operation code 2'b10 (store-left): result byte i is register byte i+3-k when i <= k, and memory byte i otherwise.
- R7: Operation code 2'b11 (store-right): result byte i is register byte i-k when i >= k, and memory byte i otherwise.
- R8: out_is_store equals bit 1 of the captured operation code, which is 1 for the two store operations.
- R9: In a cycle with in_valid low, out_data, out_addr and out_is_store keep their previous values, whatever the other inputs carry.
- R10: At the boundary offsets the whole source word passes through unchanged: load-left with k=3 and load-right with k=0 give the memory word, and store-left with k=3 and store-right with k=0 give the register word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input operands valid this cycle |
| in_op | input | 2 | Operation: 00 load-left, 01 load-right, 10 store-left, 11 store-right |
| in_addr | input | ADDR_W | Unaligned byte address |
| in_mem | input | DATA_W | Word read from the aligned address |
| in_reg | input | DATA_W | Current register contents |
| out_valid | output | 1 | Result valid strobe |
| out_is_store | output | 1 | Result is a memory word to store |
| out_data | output | DATA_W | Merged register value or memory word |
| out_addr | output | ADDR_W | Word-aligned address |

## Verification
The bench builds the unit with its default widths: a 32-bit data word, which gives four byte lanes and a two-bit offset, and a 32-bit address. At these widths every operation can be combined with every offset. The first pass is a directed sweep of all sixteen pairs with distinct byte patterns, so a lane that is misrouted shows up in the data. A randomized phase follows. It mixes back-to-back inputs with idle gaps that carry junk operands, which exercises the hold behaviour and the one-cycle strobe timing. Random upper address bits check that the alignment clears only the two low bits.

// File: rtl/uwm_pkg.sv
// Package: shared operation encoding for the unaligned word merge unit.
// Assumes bit 1 of the code separates loads (0) from stores (1).
package uwm_pkg;
    typedef enum logic [1:0] {
        OP_LOAD_LEFT   = 2'b00,
        OP_LOAD_RIGHT  = 2'b01,
        OP_STORE_LEFT  = 2'b10,
        OP_STORE_RIGHT = 2'b11
    } uwm_op_e;
endpackage

// File: rtl/uwm_load_merge.sv
// Module: uwm_load_merge
// Combinational byte-lane merge for the load-left and load-right operations.
// Each result lane takes either a rotated memory byte or the register's own byte,
// depending on the byte offset. Assumes DATA_W is a power-of-two multiple of 8.
module uwm_load_merge #(
    parameter int DATA_W = 32,
    parameter int BYTES  = DATA_W / 8,
    parameter int LB     = $clog2(BYTES)
) (
    input  logic [LB-1:0]     offset,
    input  logic              right,
    input  logic [DATA_W-1:0] mem_word,
    input  logic [DATA_W-1:0] reg_word,
    output logic [DATA_W-1:0] merged
);
    for (genvar i = 0; i < BYTES; i++) begin : g_lane
        logic [LB-1:0] left_src;
        logic [LB-1:0] right_src;
        logic          left_take_mem;
        logic          right_take_mem;

        // Compute the memory lane feeding this result lane for each direction.
        always_comb begin
            left_src       = LB'(i + int'(offset) + 1);
            right_src      = LB'(i + int'(offset));
            left_take_mem  = (i + int'(offset)) >= (BYTES - 1);
            right_take_mem = (i + int'(offset)) <= (BYTES - 1);
        end

        // Pick the memory byte or keep the register byte for this lane.
        always_comb begin
            if (right) begin
                merged[i*8 +: 8] = right_take_mem ? mem_word[int'(right_src)*8 +: 8]
                                                  : reg_word[i*8 +: 8];
            end else begin
                merged[i*8 +: 8] = left_take_mem ? mem_word[int'(left_src)*8 +: 8]
                                                 : reg_word[i*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/uwm_store_merge.sv
// Module: uwm_store_merge
// Combinational byte-lane merge for the store-left and store-right operations.
// Each lane of the new memory word takes a rotated register byte or keeps the
// old memory byte, depending on the byte offset. Assumes DATA_W = 8 * 2^n.
module uwm_store_merge #(
    parameter int DATA_W = 32,
    parameter int BYTES  = DATA_W / 8,
    parameter int LB     = $clog2(BYTES)
) (
    input  logic [LB-1:0]     offset,
    input  logic              right,
    input  logic [DATA_W-1:0] mem_word,
    input  logic [DATA_W-1:0] reg_word,
    output logic [DATA_W-1:0] merged
);
    for (genvar i = 0; i < BYTES; i++) begin : g_lane
        logic [LB-1:0] left_src;
        logic [LB-1:0] right_src;
        logic          left_take_reg;
        logic          right_take_reg;

        // Compute the register lane feeding this memory lane for each direction.
        always_comb begin
            left_src       = LB'(i - int'(offset) - 1);
            right_src      = LB'(i - int'(offset));
            left_take_reg  = i <= int'(offset);
            right_take_reg = i >= int'(offset);
        end

        // Pick the register byte or keep the old memory byte for this lane.
        always_comb begin
            if (right) begin
                merged[i*8 +: 8] = right_take_reg ? reg_word[int'(right_src)*8 +: 8]
                                                  : mem_word[i*8 +: 8];
            end else begin
                merged[i*8 +: 8] = left_take_reg ? reg_word[int'(left_src)*8 +: 8]
                                                 : mem_word[i*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/uwm_out_reg.sv
// Module: uwm_out_reg
// Output stage: captures the merged word, aligned address and kind on a valid
// input and raises a one-cycle strobe. Holds the data while the input is idle.
module uwm_out_reg #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [DATA_W-1:0] data_d,
    input  logic [ADDR_W-1:0] addr_d,
    input  logic              store_d,
    output logic              valid_q,
    output logic [DATA_W-1:0] data_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic              store_q
);
    // Strobe follows the input valid by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= load_en;
    end

    // Payload loads only on a valid input and holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            addr_q  <= '0;
            store_q <= 1'b0;
        end else if (load_en) begin
            data_q  <= data_d;
            addr_q  <= addr_d;
            store_q <= store_d;
        end
    end

    // R2: strobe appears after a valid input.
    a_r2_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> valid_q);
    // R2: no strobe without a valid input.
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> !valid_q);
    // R9: payload holds across idle cycles.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> ($stable(data_q) && $stable(addr_q) && $stable(store_q)));
endmodule

// File: rtl/uwm_unit.sv
// Module: uwm_unit (top)
// Byte merging for the four partial-word load and store operations. Picks the
// load or store merge by operation, aligns the address and registers the result.
// Assumes the register operand is the true current register contents.
module uwm_unit
    import uwm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        in_op,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_mem,
    input  logic [DATA_W-1:0] in_reg,
    output logic              out_valid,
    output logic              out_is_store,
    output logic [DATA_W-1:0] out_data,
    output logic [ADDR_W-1:0] out_addr
);
    localparam int BYTES = DATA_W / 8;
    localparam int LB    = $clog2(BYTES);

    logic [LB-1:0]     offset;
    logic [DATA_W-1:0] load_word;
    logic [DATA_W-1:0] store_word;
    logic [DATA_W-1:0] next_word;
    logic [ADDR_W-1:0] aligned_addr;
    logic              is_store;
    logic              is_right;

    // Decode the operation and split the address into word and byte offset.
    always_comb begin
        offset       = in_addr[LB-1:0];
        aligned_addr = {in_addr[ADDR_W-1:LB], {LB{1'b0}}};
        is_store     = in_op[1];
        is_right     = in_op[0];
    end

    uwm_load_merge #(.DATA_W(DATA_W)) u_load (
        .offset  (offset),
        .right   (is_right),
        .mem_word(in_mem),
        .reg_word(in_reg),
        .merged  (load_word)
    );

    uwm_store_merge #(.DATA_W(DATA_W)) u_store (
        .offset  (offset),
        .right   (is_right),
        .mem_word(in_mem),
        .reg_word(in_reg),
        .merged  (store_word)
    );

    // Choose the merge path that matches the operation kind.
    always_comb begin
        next_word = is_store ? store_word : load_word;
    end

    uwm_out_reg #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_en(in_valid),
        .data_d (next_word),
        .addr_d (aligned_addr),
        .store_d(is_store),
        .valid_q(out_valid),
        .data_q (out_data),
        .addr_q (out_addr),
        .store_q(out_is_store)
    );

    // R3: output address is the input word address with the low bits cleared.
    a_r3_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_addr[LB-1:0] == '0 &&
                      out_addr[ADDR_W-1:LB] == $past(in_addr[ADDR_W-1:LB])));
    // R8: kind flag follows the store bit of the operation.
    a_r8_kind: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_is_store == $past(in_op[1])));
    // R10: load-right at offset zero returns the memory word.
    a_r10_lr_whole: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_LOAD_RIGHT && in_addr[LB-1:0] == '0)
        |=> (out_data == $past(in_mem)));
    // R10: store-right at offset zero writes the register word.
    a_r10_sr_whole: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_STORE_RIGHT && in_addr[LB-1:0] == '0)
        |=> (out_data == $past(in_reg)));
    // R10: load-left at the top offset returns the memory word.
    a_r10_ll_whole: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_LOAD_LEFT && in_addr[LB-1:0] == LB'(BYTES - 1))
        |=> (out_data == $past(in_mem)));
endmodule

// File: tb/uwm_unit_test.sv
// Scoreboard bench: the driver pushes expected results, the monitor pops and compares.
module uwm_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_op = 2'b00;
    logic [31:0] in_addr = '0;
    logic [31:0] in_mem = '0;
    logic [31:0] in_reg = '0;
    logic        out_valid;
    logic        out_is_store;
    logic [31:0] out_data;
    logic [31:0] out_addr;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [31:0] d;
        logic [31:0] a;
        logic        st;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    uwm_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_addr(in_addr), .in_mem(in_mem), .in_reg(in_reg),
        .out_valid(out_valid), .out_is_store(out_is_store),
        .out_data(out_data), .out_addr(out_addr)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %08h expected %08h", req, act, exp);
        end
    endtask

    // Expected result from the mask-and-shift formulas.
    function automatic logic [31:0] model(input logic [1:0] op, input logic [31:0] a,
                                          input logic [31:0] m, input logic [31:0] r);
        int s;
        s = int'(a[1:0]) * 8;
        case (op)
            2'b00:   return (r & (32'h00FFFFFF >> s)) | (m << (24 - s));
            2'b01:   return (r & (32'hFFFFFF00 << (24 - s))) | (m >> s);
            2'b10:   return (m & (32'hFFFFFF00 << s)) | (r >> (24 - s));
            default: return (m & (32'h00FFFFFF >> (24 - s))) | (r << s);
        endcase
    endfunction

    // Drive one valid input at the falling edge and push the expected result.
    task automatic drive(input logic [1:0] op, input logic [31:0] a,
                         input logic [31:0] m, input logic [31:0] r, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_addr = a; in_mem = m; in_reg = r;
        e.d = model(op, a, m, r);
        e.a = {a[31:2], 2'b00};
        e.st = op[1];
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Idle cycle with junk operands, which must leave the outputs untouched.
    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        in_op = 2'($urandom); in_addr = $urandom; in_mem = $urandom; in_reg = $urandom;
    endtask

    // Monitor: compare each strobed result against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R2 unexpected strobe", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(out_data == e.d, e.tag, out_data, e.d);
                check(out_addr == e.a, "R3 address", out_addr, e.a);
                check(out_is_store == e.st, "R8 kind", 32'(out_is_store), 32'(e.st));
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] held_d;
        logic [31:0] held_a;
        logic        held_s;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset values while reset is held
        check(out_valid == 1'b0 && out_data == '0 && out_addr == '0 && out_is_store == 1'b0,
              "R1 reset state", out_data, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(out_valid == 1'b0 && out_data == '0, "R1 after release", out_data, 32'd0);

        // Directed sweep of every operation and offset (R4, R5, R6, R7, R10).
        for (int op = 0; op < 4; op++) begin
            for (int k = 0; k < 4; k++) begin
                string tag;
                bit edge_case;
                edge_case = (op == 0 && k == 3) || (op == 1 && k == 0) ||
                            (op == 2 && k == 3) || (op == 3 && k == 0);
                case (op)
                    0: tag = "R4 load-left";
                    1: tag = "R5 load-right";
                    2: tag = "R6 store-left";
                    default: tag = "R7 store-right";
                endcase
                if (edge_case) tag = {tag, " R10 boundary"};
                drive(2'(op), 32'h8000_1000 + 32'(k), 32'hA1B2C3D4, 32'h11223344, tag);
            end
        end
        idle();
        idle();

        // R9: outputs hold over idle cycles with junk inputs.
        @(negedge clk);
        held_d = out_data; held_a = out_addr; held_s = out_is_store;
        idle(); idle(); idle();
        @(negedge clk);
        check(out_data == held_d, "R9 data hold", out_data, held_d);
        check(out_addr == held_a, "R9 address hold", out_addr, held_a);
        check(out_is_store == held_s, "R9 kind hold", 32'(out_is_store), 32'(held_s));
        check(out_valid == 1'b0, "R2 idle no strobe", 32'(out_valid), 32'd0);

        // Randomized mix of back-to-back and gapped inputs.
        for (int n = 0; n < 400; n++) begin
            logic [1:0] op;
            op = 2'($urandom);
            drive(op, $urandom, $urandom, $urandom,
                  op == 2'b00 ? "R4 random" : op == 2'b01 ? "R5 random" :
                  op == 2'b10 ? "R6 random" : "R7 random");
            if ($urandom_range(0, 3) == 0) idle();
        end
        idle();
        idle();
        @(negedge clk);
        check(sb.size() == 0, "R2 all results strobed", 32'(sb.size()), 32'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule